// File: doc/BRIEF.md
# Serial EEPROM Word Read Controller

This block is the host side of a read from a three-wire serial EEPROM that is organised as 128 words of 16 bits. A client presents a word address and pulses a start strobe. The controller then drives the chip-select, serial-clock, data-out and write-protect pins through a fixed sequence. It shifts out an 11-bit read command and clocks 16 data bits back in. It returns the word with a single-cycle done pulse.

All pin activity is divided into phases. A phase lasts a programmable number of system clocks, which sets the serial clock rate. Each phase applies one pin change, and the pin changes follow a fixed order: a preamble that raises chip select, the command bits, the data bits, and a postamble that releases chip select. The pin decode is a pure function of a step index and a captured command frame, so the pins can never drift away from the step the controller is in.

Top module: `mw_eeprom_reader`

## Requirements
- R1: During and after reset, and whenever idle, the pins are chip select 0, serial clock 1, data-out 0 and protect 1; busy and done are 0; the read word is 0 until the first read completes.
- R2: A start strobe seen at a clock edge while not busy is accepted. Busy is 1 from the next cycle, and the address and divider are captured at that edge.
- R3: Every step lasts one phase of max(divider,1) system clocks; a divider of 0 behaves as 1.
- R4: The preamble is six phases, in this order: data-out low; clock low; protect low; one settle phase with no change; chip select high; clock high.
- R5: The command is 11 bits, binary 110 followed by the 8-bit address, sent MSB first and unmodified. Each bit takes one phase with data-out equal to the bit and the clock low, then one phase with the clock high. One more phase follows with data-out low and the clock high.
- R6: The data stage has 16 clock periods, each a low phase then a high phase. Data-in is sampled on the last system clock of each high phase and shifted in MSB first.
- R7: The postamble is four phases, in this order: clock low; chip select low; protect high; clock high. Done is 1 on the last system clock of the last phase. The read word is valid with done and is held until the next accepted start.
- R8: Busy stays 1 through the done cycle and is 0 on the cycle after it. Start strobes that arrive while busy, including in the done cycle, are ignored.
- R9: Protect is low whenever chip select is high, and data-out is low whenever chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Read request strobe |
| word_addr | input | 8 | Word address of the read |
| phase_div | input | 8 | System clocks per pin phase (0 acts as 1) |
| busy | output | 1 | Read in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Word read from the memory |
| ee_cs | output | 1 | Chip select to the memory |
| ee_sk | output | 1 | Serial clock to the memory |
| ee_do | output | 1 | Serial data towards the memory |
| ee_prot | output | 1 | Protect-enable line |
| ee_di | input | 1 | Serial data from the memory |

## Verification
The pins are decoded directly from the step index and the captured frame. A wrong step count, a wrong phase length or a corrupted frame therefore shows up on the serial clock, chip select, protect or data-out pins within one phase, and the clock-by-clock comparison catches it on that same system clock. An error in the capture path is not visible on the pins. It shows up only as a wrong word at the done pulse, or as a held word that changes while idle. A memory model in the bench decodes the opcode and address from the serial clock edges, so a frame that is wrong on the wire is reported even if the pin timing is right.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef struct packed {
    logic cs;
    logic sk;
    logic dout;
    logic prot;
  } mw_pins_t;

  localparam logic [2:0] MW_READ_OP = 3'b110;
  localparam int MW_CMD_BASE = 6;

  function automatic int mw_data_base(input int frame_w);
    return MW_CMD_BASE + 2 * frame_w + 1;
  endfunction

  function automatic int mw_post_base(input int frame_w, input int data_w);
    return mw_data_base(frame_w) + 2 * data_w;
  endfunction

  function automatic int mw_last_step(input int frame_w, input int data_w);
    return mw_post_base(frame_w, data_w) + 3;
  endfunction

  function automatic int mw_step_bits(input int frame_w, input int data_w);
    return $clog2(mw_last_step(frame_w, data_w) + 1);
  endfunction
endpackage

// File: rtl/mw_phase_timer.sv
module mw_phase_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [DIV_W-1:0] div_in,
  output logic             phase_end
);
  localparam logic [DIV_W-1:0] ONE = {{(DIV_W-1){1'b0}}, 1'b1};

  logic [DIV_W-1:0] len_q;
  logic [DIV_W-1:0] cnt_q;

  assign phase_end = run && (cnt_q == len_q - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= ONE;
      cnt_q <= '0;
    end else if (load) begin
      len_q <= (div_in == '0) ? ONE : div_in;
      cnt_q <= '0;
    end else if (run) begin
      cnt_q <= phase_end ? '0 : cnt_q + ONE;
    end
  end
endmodule

// File: rtl/mw_step_seq.sv
module mw_step_seq
  import mw_pkg::*;
#(
  parameter int FRAME_W = 11,
  parameter int DATA_W  = 16,
  parameter int STEP_W  = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic               phase_end,
  input  logic [FRAME_W-1:0] frame_in,
  output logic               busy,
  output logic               sample_now,
  output logic               last_end,
  output mw_pins_t           pins
);
  localparam int D0    = mw_data_base(FRAME_W);
  localparam int P0    = mw_post_base(FRAME_W, DATA_W);
  localparam int LASTI = mw_last_step(FRAME_W, DATA_W);
  localparam logic [STEP_W-1:0] LAST_IDX = STEP_W'(LASTI);

  logic [STEP_W-1:0]  idx_q;
  logic [FRAME_W-1:0] frame_q;
  logic [FRAME_W-1:0] frame_sh;
  logic               busy_q;
  int                 i;
  int                 bitn;
  logic               in_cmd;
  logic               in_data;

  assign busy     = busy_q;
  assign last_end = busy_q && phase_end && (idx_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      frame_q <= '0;
    end else if (accept) begin
      busy_q  <= 1'b1;
      idx_q   <= '0;
      frame_q <= frame_in;
    end else if (busy_q && phase_end) begin
      if (idx_q == LAST_IDX) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  always_comb begin
    i        = int'(idx_q);
    in_cmd   = (i >= MW_CMD_BASE) && (i < D0 - 1);
    in_data  = (i >= D0) && (i < P0);
    bitn     = (i - MW_CMD_BASE) / 2;
    frame_sh = frame_q << bitn;
    pins     = '{cs: 1'b0, sk: 1'b1, dout: 1'b0, prot: 1'b1};
    sample_now = 1'b0;
    if (busy_q) begin
      pins.cs   = (i >= 4) && (i <= P0);
      pins.prot = !((i >= 2) && (i <= P0 + 1));
      if (in_cmd) begin
        pins.sk   = ((i - MW_CMD_BASE) % 2) == 1;
        pins.dout = frame_sh[FRAME_W-1];
      end else if (in_data) begin
        pins.sk    = ((i - D0) % 2) == 1;
        sample_now = phase_end && (((i - D0) % 2) == 1);
      end else begin
        pins.sk = (i == 0) || (i == 5) || (i == D0 - 1) || (i == LASTI);
      end
    end
  end
endmodule

// File: rtl/mw_capture.sv
module mw_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sample,
  input  logic              din,
  output logic [DATA_W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word <= '0;
    else if (clear)  word <= '0;
    else if (sample) word <= {word[DATA_W-2:0], din};
  end
endmodule

// File: rtl/mw_eeprom_reader.sv
module mw_eeprom_reader
  import mw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] word_addr,
  input  logic [DIV_W-1:0]  phase_div,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_do,
  output logic              ee_prot,
  input  logic              ee_di
);
  localparam int FRAME_W = 3 + ADDR_W;
  localparam int STEP_W  = mw_step_bits(FRAME_W, DATA_W);

  logic     accept;
  logic     phase_end;
  logic     sample_now;
  logic     last_end;
  mw_pins_t pins;

  assign accept = start && !busy;

  mw_phase_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(accept), .run(busy),
    .div_in(phase_div), .phase_end(phase_end)
  );

  mw_step_seq #(.FRAME_W(FRAME_W), .DATA_W(DATA_W), .STEP_W(STEP_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .phase_end(phase_end),
    .frame_in({MW_READ_OP, word_addr}), .busy(busy),
    .sample_now(sample_now), .last_end(last_end), .pins(pins)
  );

  mw_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .clear(accept), .sample(sample_now),
    .din(ee_di), .word(rdata)
  );

  assign done    = last_end;
  assign ee_cs   = pins.cs;
  assign ee_sk   = pins.sk;
  assign ee_do   = pins.dout;
  assign ee_prot = pins.prot;
endmodule

// File: rtl/mw_eeprom_reader_chk.sv
module mw_eeprom_reader_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic sample_now,
  input logic ee_cs,
  input logic ee_sk,
  input logic ee_do,
  input logic ee_prot
);
  a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ee_cs && ee_sk && !ee_do && ee_prot));

  a_r2_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  a_r8_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  a_r8_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  a_r6_sample_high: assert property (@(posedge clk) disable iff (!rst_n)
    sample_now |-> (ee_sk && ee_cs));

  a_r7_done_pins: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ee_sk && !ee_cs && ee_prot));

  a_r9_prot_low_cs: assert property (@(posedge clk) disable iff (!rst_n)
    ee_cs |-> !ee_prot);

  a_r9_do_low_no_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_cs |-> !ee_do);
endmodule

bind mw_eeprom_reader mw_eeprom_reader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .sample_now(sample_now), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_do(ee_do),
  .ee_prot(ee_prot)
);

// File: tb/tb_mw_eeprom_reader.sv
module tb_mw_eeprom_reader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  word_addr = '0;
  logic [7:0]  phase_div = 8'd1;
  logic        busy, done, ee_cs, ee_sk, ee_do, ee_prot;
  logic        ee_di = 1'b0;
  logic [15:0] rdata;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  mw_eeprom_reader dut (
    .clk(clk), .rst_n(rst_n), .start(start), .word_addr(word_addr),
    .phase_div(phase_div), .busy(busy), .done(done), .rdata(rdata),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_do(ee_do), .ee_prot(ee_prot),
    .ee_di(ee_di)
  );

  // ---------------- memory model ----------------
  logic [15:0] mem [128];
  logic        prev_sk = 1'b1;
  logic        got_start = 1'b0;
  int          nbits = 0;
  logic [10:0] cmd_sh = '0;
  logic [6:0]  mem_addr = '0;
  int          dptr = 0;
  logic [7:0]  sent_addr = '0;

  initial for (int k = 0; k < 128; k++) mem[k] = 16'(k * 40503) ^ 16'hA5C3;

  always @(negedge clk) begin
    if (!ee_cs) begin
      got_start <= 1'b0;
      nbits <= 0;
      dptr <= 0;
      ee_di <= 1'b0;
    end else if (ee_sk && !prev_sk) begin
      if (!got_start) begin
        if (ee_do) begin
          got_start <= 1'b1;
          nbits <= 1;
          cmd_sh <= 11'd1;
        end
      end else if (nbits < 11) begin
        cmd_sh <= {cmd_sh[9:0], ee_do};
        nbits <= nbits + 1;
        if (nbits == 10) begin
          mem_addr <= {cmd_sh[5:0], ee_do};
          n_checks++;
          if ({cmd_sh[9:0], ee_do} != {3'b110, sent_addr}) begin
            n_fail++;
            $display("FAIL R5 frame on wire act=%b exp=%b", {cmd_sh[9:0], ee_do}, {3'b110, sent_addr});
          end
        end
      end else begin
        ee_di <= mem[mem_addr][15 - dptr];
        dptr <= dptr + 1;
      end
    end
    prev_sk <= ee_sk;
  end

  // ---------------- reference model ----------------
  logic [5:0]  exp_q [$];
  string       tag_q [$];
  logic [15:0] exp_word = '0;
  logic        last_busy = 1'b0;
  logic        c_cs, c_sk, c_do, c_pr;
  int          c_n;

  task automatic put(input string tag, input logic fin);
    for (int k = 0; k < c_n; k++) begin
      // {cs, sk, do, prot, busy, done}
      exp_q.push_back({c_cs, c_sk, c_do, c_pr, 1'b1, fin && (k == c_n - 1)});
      tag_q.push_back(tag);
    end
  endtask

  task automatic build(input logic [7:0] a, input logic [7:0] d);
    logic [10:0] fr;
    fr = {3'b110, a};
    c_n = (d == 0) ? 1 : int'(d);
    sent_addr = a;
    c_cs = 0; c_sk = 1; c_do = 0; c_pr = 1;
    c_do = 0; put("R4", 0);
    c_sk = 0; put("R4", 0);
    c_pr = 0; put("R4", 0);
    put("R4", 0);
    c_cs = 1; put("R4", 0);
    c_sk = 1; put("R4", 0);
    for (int b = 10; b >= 0; b--) begin
      c_do = fr[b]; c_sk = 0; put("R5", 0);
      c_sk = 1; put("R5", 0);
    end
    c_do = 0; put("R5", 0);
    for (int b = 0; b < 16; b++) begin
      c_sk = 0; put("R6", 0);
      c_sk = 1; put("R6", 0);
    end
    c_sk = 0; put("R7", 0);
    c_cs = 0; put("R7", 0);
    c_pr = 1; put("R7", 0);
    c_sk = 1; put("R7", 1);
    exp_word = mem[a[6:0]];
  endtask

  always @(posedge clk) begin
    if (rst_n && start && !last_busy) build(word_addr, phase_div);
    #2;
    if (rst_n) begin
      logic [5:0] e;
      logic [5:0] act;
      string t;
      act = {ee_cs, ee_sk, ee_do, ee_prot, busy, done};
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        last_busy = 1'b1;
        if (e[0]) begin
          n_checks++;
          if (rdata !== exp_word) begin
            n_fail++;
            $display("FAIL R7 word at done act=%h exp=%h", rdata, exp_word);
          end
        end
      end else begin
        e = 6'b010100;
        t = "R1";
        last_busy = 1'b0;
        n_checks++;
        if (rdata !== exp_word) begin
          n_fail++;
          $display("FAIL R7 held word act=%h exp=%h", rdata, exp_word);
        end
      end
      n_checks++;
      if (act !== e) begin
        n_fail++;
        $display("FAIL %s pins{cs,sk,do,prot,busy,done} act=%b exp=%b", t, act, e);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic wait_idle();
    do @(negedge clk); while (exp_q.size() != 0 || last_busy);
    repeat (3) @(negedge clk);
  endtask

  task automatic read(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    word_addr = a; phase_div = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    n_checks++;
    if ({ee_cs, ee_sk, ee_do, ee_prot, busy, done} !== 6'b010100 || rdata !== 16'h0) begin
      n_fail++;
      $display("FAIL R1 reset state act=%b/%h exp=010100/0000",
               {ee_cs, ee_sk, ee_do, ee_prot, busy, done}, rdata);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    read(8'd5, 8'd1);      // R2 R3 basic
    read(8'd127, 8'd3);    // R3 longer phases, top word
    read(8'd0, 8'd0);      // R3 divider 0 acts as 1
    read(8'd200, 8'd2);    // R5 address MSB sent unmodified
    // R8: extra strobes while busy are ignored
    @(negedge clk);
    word_addr = 8'h55; phase_div = 8'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    word_addr = 8'h12; phase_div = 8'd4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    // R8: start held high across done, re-accepted only after idle
    @(negedge clk);
    word_addr = 8'd9; phase_div = 8'd1; start = 1'b1;
    repeat (150) @(negedge clk);
    start = 1'b0;
    wait_idle();
    read(8'd64, 8'd5);     // R6 data capture with slow clock
    finish_run();
  end
endmodule